// File: doc/BRIEF.md
# Asynchronous Static RAM Port Sequencer

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 256K words by 16 bits with separate lower and upper byte selects. The requester raises a one-cycle request with a direction flag, an 18-bit word address, 16 bits of write data and a 2-bit byte-enable. The block then drives the memory's two chip enables, which have opposite polarity, together with the write strobe, the output enable and the two byte selects. It runs each access for a whole number of clock cycles. Every phase length is derived at elaboration from nanosecond limits and the clock period, rounded up.

Reads end with the captured word and a one-cycle valid pulse. Writes end after a hold cycle. After a read, the block keeps the data bus released for a turnaround window before it can drive the bus again. Between accesses the memory is fully deselected so that it falls into its standby state. The data bus is split into output, output-enable and input, and the pad is left to the chip level.

Top module: `asram_port`

## Requirements
- R1: During reset, and in every cycle in which `busy` is low, both enables are inactive (`memCeN`=1, `memCe`=0), `memWeN`, `memOeN`, `memLbN` and `memUbN` are 1, and `memDqOe` is 0.
- R2: A read keeps the memory selected, with `memWeN` high, and holds `memOeN` low for exactly RD cycles. RD is 14 at the default 4 ns clock, the larger of the 55 ns address-access and read-cycle limits.
- R3: Read data is sampled on the last cycle of `memOeN` low. It is returned on `rdData` with `rdValid` high for exactly one cycle. A lane whose byte-enable bit is 0 reads as zero, where bit 0 is the lower lane `memDq[7:0]` and bit 1 is the upper lane `memDq[15:8]`.
- R4: A write holds `memWeN` low for exactly WP cycles, where WP is 12 at default: the largest of the 40 ns pulse, 25 ns data-setup and 45 ns address-valid limits. `memDqOe` stays high and `memDqOut` stays stable throughout the pulse and for one cycle after it. Only the lanes whose byte select is low (`memLbN`/`memUbN` = inverted byte-enable) are written.
- R5: The address is stable for the whole time the memory is selected. A write keeps the memory selected for at least 14 cycles (55 ns write cycle).
- R6: `memOeN` and `memWeN` are never low together, and the data bus is never driven while `memOeN` is low.
- R7: The data bus is not driven within 5 cycles (20 ns) after `memOeN` rises.
- R8: A request presented while `busy` is high is ignored and leaves the memory unchanged.
- R9: A request with byte-enable 00 produces no write strobe and no output-enable pulse. A no-op read still returns `rdValid` with `rdData` = 0.
- R10: `busy` is high in the cycle after a request is accepted. It stays high until the access and any turnaround are over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, sampled while not busy |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wrData | input | 16 | Write data |
| byteEn | input | 2 | Lane enables, bit 0 lower byte |
| busy | output | 1 | Access in progress |
| rdValid | output | 1 | One-cycle read-data-valid pulse |
| rdData | output | 16 | Captured read data |
| memAddr | output | 18 | Memory address |
| memCeN | output | 1 | Active-low chip enable |
| memCe | output | 1 | Active-high chip enable |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memLbN | output | 1 | Active-low lower byte select |
| memUbN | output | 1 | Active-low upper byte select |
| memDqOut | output | 16 | Data driven toward the memory |
| memDqOe | output | 1 | Drive enable for the data bus |
| memDqIn | input | 16 | Data returned from the memory |

## Verification
A new request can arrive in the same cycle as the last busy cycle of the current access. In that cycle the ignore rule (R8) and the completion of the access (R10) meet. The bench holds a write request high across the whole tail of a read and then keeps it high into the first idle cycle. It requires the read to return correct data, the held write to be accepted exactly once at that idle cycle and never earlier, and a later read-back to show only that write's effect.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NOOP,
    ST_RD,
    ST_RTURN,
    ST_WSET,
    ST_WPUL,
    ST_WHOLD
  } ctlState_t;

  typedef struct packed {
    logic load;     // latch request fields
    logic select;   // lane selects follow latched byte enables
    logic drive;    // put write data on the bus
    logic capture;  // sample the bus into the read register
  } dpStrobe_t;

  function automatic int cyclesFor(input int ps, input int clkPs);
    return (ps + clkPs - 1) / clkPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int WSET_LEN = 1,
  parameter int WPUL_LEN = 12,
  parameter int RD_LEN   = 14,
  parameter int TURN_LEN = 5,
  parameter int LANES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             req,
  input  logic             wr,
  input  logic [LANES-1:0] reqBe,
  output dpStrobe_t        strb,
  output logic             busy,
  output logic             memCeN,
  output logic             memCe,
  output logic             memWeN,
  output logic             memOeN
);

  localparam int LONGEST = maxOf(maxOf(WSET_LEN, WPUL_LEN), maxOf(RD_LEN, TURN_LEN));
  localparam int CNT_W   = $clog2(LONGEST + 1);

  ctlState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             isWr;
  logic             lastCnt;
  logic             selected;

  assign lastCnt = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req) begin
          isWr <= wr;
          if (reqBe == '0) begin
            state <= ST_NOOP;
          end else if (wr) begin
            state <= ST_WSET;
            cnt   <= CNT_W'(WSET_LEN - 1);
          end else begin
            state <= ST_RD;
            cnt   <= CNT_W'(RD_LEN - 1);
          end
        end
        ST_NOOP: state <= ST_IDLE;
        ST_RD: begin
          if (lastCnt) begin
            state <= ST_RTURN;
            cnt   <= CNT_W'(TURN_LEN - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_RTURN: begin
          if (lastCnt) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_WSET: begin
          if (lastCnt) begin
            state <= ST_WPUL;
            cnt   <= CNT_W'(WPUL_LEN - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WPUL: begin
          if (lastCnt) state <= ST_WHOLD;
          else cnt <= cnt - 1'b1;
        end
        ST_WHOLD: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    selected     = (state == ST_RD) || (state == ST_WSET) ||
                   (state == ST_WPUL) || (state == ST_WHOLD);
    strb.load    = (state == ST_IDLE) && req;
    strb.select  = selected;
    strb.drive   = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_WHOLD);
    strb.capture = ((state == ST_RD) && lastCnt) || ((state == ST_NOOP) && !isWr);
    busy         = (state != ST_IDLE);
    memCeN       = !selected;
    memCe        = selected;
    memWeN       = (state != ST_WPUL);
    memOeN       = (state != ST_RD);
  end

  // ---------------- checks ----------------
  logic [CNT_W-1:0] weLow;
  logic [CNT_W-1:0] sinceOe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLow   <= '0;
      sinceOe <= CNT_W'(TURN_LEN);
    end else begin
      weLow <= memWeN ? '0 : weLow + 1'b1;
      if (!memOeN) sinceOe <= '0;
      else if (sinceOe < CNT_W'(TURN_LEN)) sinceOe <= sinceOe + 1'b1;
    end
  end

  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memCeN && !memCe && memWeN && memOeN));

  a_r4_pulse_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLow == CNT_W'(WPUL_LEN)));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    (memOeN || memWeN));

  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    strb.drive |-> (sinceOe >= CNT_W'(TURN_LEN)));

  a_r9_noop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && req && reqBe == '0) |=> (memWeN && memOeN && memCeN));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LANES-1:0]  reqBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  laneSelN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] laneCap;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneSelN[l]       = !(strb.select && beQ[l]);
    assign laneCap[l*8 +: 8] = beQ[l] ? dqIn[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      beQ     <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ <= reqAddr;
        dataQ <= reqData;
        beQ   <= reqBe;
      end
      if (strb.capture) rdData <= laneCap;
      rdValid <= strb.capture;
    end
  end

  assign memAddr = addrQ;
  assign dqOut   = dataQ;
  assign dqOe    = strb.drive;

  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  a_r4_data_steady: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe && $past(dqOe)) |-> $stable(dqOut));

endmodule

// File: rtl/asram_port.sv
module asram_port
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int CLK_PS  = 4000,
  parameter int WP_PS   = 40000,
  parameter int DS_PS   = 25000,
  parameter int AW_PS   = 45000,
  parameter int WC_PS   = 55000,
  parameter int AA_PS   = 55000,
  parameter int RC_PS   = 55000,
  parameter int TURN_PS = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  input  logic [1:0]        byteEn,
  output logic              busy,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [15:0]       memDqOut,
  output logic              memDqOe,
  input  logic [15:0]       memDqIn
);

  localparam int LANES    = 2;
  localparam int WP_CYC   = cyclesFor(WP_PS, CLK_PS);
  localparam int DS_CYC   = cyclesFor(DS_PS, CLK_PS);
  localparam int AW_CYC   = cyclesFor(AW_PS, CLK_PS);
  localparam int WC_CYC   = cyclesFor(WC_PS, CLK_PS);
  localparam int AA_CYC   = cyclesFor(AA_PS, CLK_PS);
  localparam int RC_CYC   = cyclesFor(RC_PS, CLK_PS);
  localparam int TURN_CYC = cyclesFor(TURN_PS, CLK_PS);
  localparam int WPUL_LEN = maxOf(maxOf(WP_CYC, DS_CYC), AW_CYC);
  localparam int WSET_LEN = maxOf(1, WC_CYC - WPUL_LEN - 1);
  localparam int RD_LEN   = maxOf(AA_CYC, RC_CYC);
  localparam int TURN_LEN = maxOf(1, TURN_CYC);

  if (WP_CYC == 0 || DS_CYC == 0 || AA_CYC == 0 || TURN_CYC == 0) begin : g_badTiming
    $error("asram_port: every phase count must be at least one cycle");
  end

  dpStrobe_t  strb;
  logic [1:0] laneSelN;

  asram_ctrl #(
    .WSET_LEN(WSET_LEN), .WPUL_LEN(WPUL_LEN),
    .RD_LEN(RD_LEN), .TURN_LEN(TURN_LEN), .LANES(LANES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .reqBe(byteEn),
    .strb(strb), .busy(busy),
    .memCeN(memCeN), .memCe(memCe), .memWeN(memWeN), .memOeN(memOeN)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(addr), .reqData(wrData), .reqBe(byteEn),
    .memAddr(memAddr), .laneSelN(laneSelN),
    .dqOut(memDqOut), .dqOe(memDqOe), .dqIn(memDqIn),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign memLbN = laneSelN[0];
  assign memUbN = laneSelN[1];

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

endmodule

// File: tb/asram_port_tb.sv
module asram_port_tb;

  localparam int WP_EXP   = 12;
  localparam int RD_EXP   = 14;
  localparam int TURN_EXP = 5;
  localparam int WC_EXP   = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  byteEn = '0;
  logic        busy, rdValid;
  logic [15:0] rdData;
  logic [17:0] memAddr;
  logic        memCeN, memCe, memWeN, memOeN, memLbN, memUbN, memDqOe;
  logic [15:0] memDqOut, memDqIn;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  asram_port u_dut (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .addr(addr), .wrData(wrData),
    .byteEn(byteEn), .busy(busy), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memCe(memCe), .memWeN(memWeN),
    .memOeN(memOeN), .memLbN(memLbN), .memUbN(memUbN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] hiOf(input logic [7:0] low);
    return 10'((low * 37 + 5) & 10'h3ff);
  endfunction

  function automatic logic [17:0] mkAddr(input logic [7:0] low);
    return {hiOf(low), low};
  endfunction

  logic [15:0] refMem [256];
  logic [15:0] modMem [256];

  function automatic logic [15:0] expRead(input logic [7:0] low, input logic [1:0] be);
    logic [15:0] v = refMem[low];
    return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
  endfunction

  // ---------------- memory model and monitor ----------------
  int weRun = 0, oeRun = 0, selRun = 0, sinceOe = 1000;
  int weRises = 0, oeFalls = 0;
  int addrViol = 0, dataViol = 0, ovlViol = 0, turnViol = 0, idleViol = 0, mapViol = 0;
  bit prevSel = 0, prevWeLow = 0, prevOeLow = 0, selWrite = 0;
  logic [17:0] prevAddr = '0;
  logic [15:0] prevDq = '0;

  always_comb begin
    logic [15:0] v;
    if (!memCeN && memCe && memWeN && !memOeN) begin
      v = (oeRun >= RD_EXP) ? modMem[memAddr[7:0]] : (16'hBAD0 ^ 16'(oeRun));
      memDqIn[7:0]  = memLbN ? 8'h5A : v[7:0];
      memDqIn[15:8] = memUbN ? 8'hA5 : v[15:8];
    end else begin
      memDqIn = 16'h0000;
    end
  end

  always @(negedge clk) begin
    bit sel;
    sel = !memCeN && memCe;
    if (!rstN) begin
      if (memCeN !== 1'b1 || memCe !== 1'b0 || memWeN !== 1'b1 || memOeN !== 1'b1 || memDqOe !== 1'b0)
        idleViol++;
    end else begin
      if (sel && prevSel && memAddr != prevAddr) addrViol++;
      if (!memWeN && prevWeLow && (memDqOut != prevDq || !memDqOe)) dataViol++;
      if (!memWeN && !memOeN) ovlViol++;
      if (memDqOe && !memOeN) ovlViol++;
      if (!memOeN) sinceOe = 0; else if (sinceOe < 1000) sinceOe++;
      if (memDqOe && sinceOe <= TURN_EXP) turnViol++;
      if (!busy && (memCeN !== 1'b1 || memCe !== 1'b0 || memWeN !== 1'b1 || memOeN !== 1'b1 ||
                    memLbN !== 1'b1 || memUbN !== 1'b1 || memDqOe !== 1'b0))
        idleViol++;
      if (memWeN && prevWeLow) begin
        weRises++;
        chk(weRun == WP_EXP, "R4 write pulse cycles", weRun, WP_EXP);
        chk(memDqOe && sel, "R4 data held after pulse", {memDqOe, sel}, 2'b11);
        if (memAddr[17:8] != hiOf(memAddr[7:0])) mapViol++;
        if (!memLbN) modMem[memAddr[7:0]][7:0]  = memDqOut[7:0];
        if (!memUbN) modMem[memAddr[7:0]][15:8] = memDqOut[15:8];
      end
      if (!memWeN) selWrite = 1;
      weRun = memWeN ? 0 : weRun + 1;
      if (memOeN && prevOeLow)
        chk(oeRun == RD_EXP, "R2 output-enable cycles", oeRun, RD_EXP);
      if (!memOeN && !prevOeLow) oeFalls++;
      if (!memOeN && (memWeN !== 1'b1 || !sel)) ovlViol++;
      oeRun = memOeN ? 0 : oeRun + 1;
      if (!sel && prevSel && selWrite) begin
        chk(selRun >= WC_EXP, "R5 write select cycles", selRun, WC_EXP);
        selWrite = 0;
      end
      selRun = sel ? selRun + 1 : 0;
    end
    prevSel = sel; prevWeLow = !memWeN; prevOeLow = !memOeN;
    prevAddr = memAddr; prevDq = memDqOut;
  end

  // ---------------- stimulus ----------------
  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] low, input logic [15:0] d, input logic [1:0] be);
    int w0;
    waitIdle();
    w0 = weRises;
    req = 1; wr = 1; addr = mkAddr(low); wrData = d; byteEn = be;
    @(negedge clk);
    req = 0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (be[0]) refMem[low][7:0]  = d[7:0];
    if (be[1]) refMem[low][15:8] = d[15:8];
    waitIdle();
    chk(weRises == w0 + ((be == 2'b00) ? 0 : 1), "R9 write strobe count", weRises - w0,
        (be == 2'b00) ? 0 : 1);
  endtask

  task automatic doRead(input logic [7:0] low, input logic [1:0] be);
    int o0;
    bit got = 0;
    waitIdle();
    o0 = oeFalls;
    req = 1; wr = 0; addr = mkAddr(low); wrData = 16'hFFFF; byteEn = be;
    @(negedge clk);
    req = 0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (rdValid) got = 1;
    end
    chk(got, "R3 read valid seen", got, 1);
    chk(rdData == expRead(low, be), "R3 read data", rdData, expRead(low, be));
    @(negedge clk);
    chk(rdValid == 1'b0, "R3 valid one cycle", rdValid, 0);
    waitIdle();
    chk(oeFalls == o0 + ((be == 2'b00) ? 0 : 1), "R9 output enable count", oeFalls - o0,
        (be == 2'b00) ? 0 : 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) begin
      refMem[i] = 16'(i * 16'h0101) ^ 16'h1234;
      modMem[i] = refMem[i];
    end
    repeat (3) @(negedge clk);
    chk(memCeN && !memCe && memWeN && memOeN && memLbN && memUbN && !memDqOe,
        "R1 reset pins", {memCeN, memCe, memWeN, memOeN, memLbN, memUbN, memDqOe}, 7'b1011110);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !rdValid, "R1 idle after reset", {busy, rdValid}, 0);

    // directed: full word, single lanes
    doWrite(8'h10, 16'hC3A5, 2'b11);
    doRead(8'h10, 2'b11);
    doWrite(8'h10, 16'h0077, 2'b01);
    doRead(8'h10, 2'b11);
    doWrite(8'h10, 16'h9900, 2'b10);
    doRead(8'h10, 2'b11);
    doRead(8'h10, 2'b01);
    doRead(8'h10, 2'b10);
    // no-ops (R9)
    doWrite(8'h10, 16'h1111, 2'b00);
    doRead(8'h10, 2'b00);
    doRead(8'h10, 2'b11);

    // R8: write request held during a read is dropped
    begin
      int w0;
      bit got = 0;
      waitIdle();
      w0 = weRises;
      req = 1; wr = 0; addr = mkAddr(8'h22); byteEn = 2'b11;
      @(negedge clk);
      wr = 1; wrData = 16'hDEAD;
      repeat (3) @(negedge clk);
      req = 0;
      for (int i = 0; i < 40 && !got; i++) begin
        @(negedge clk);
        if (rdValid) got = 1;
      end
      chk(got && rdData == expRead(8'h22, 2'b11), "R8 read during ignored request", rdData,
          expRead(8'h22, 2'b11));
      waitIdle();
      chk(weRises == w0, "R8 no strobe from ignored request", weRises - w0, 0);
      doRead(8'h22, 2'b11);
    end

    // request held across the end of a read: accepted exactly once at idle
    begin
      int w0;
      bit got = 0;
      waitIdle();
      w0 = weRises;
      req = 1; wr = 0; addr = mkAddr(8'h33); byteEn = 2'b11;
      @(negedge clk);
      wr = 1; addr = mkAddr(8'h34); wrData = 16'h5EED; byteEn = 2'b11;
      while (busy) begin
        if (rdValid) begin
          got = 1;
          chk(rdData == expRead(8'h33, 2'b11), "R3 read before held request", rdData,
              expRead(8'h33, 2'b11));
        end
        @(negedge clk);
      end
      chk(got, "R3 read valid before idle", got, 1);
      @(negedge clk);
      req = 0;
      chk(busy == 1'b1, "R10 held request accepted at idle", busy, 1);
      refMem[8'h34] = 16'h5EED;
      waitIdle();
      chk(weRises == w0 + 1, "R8 held request taken once", weRises - w0, 1);
      doRead(8'h34, 2'b11);
    end

    // constrained random
    for (int n = 0; n < 160; n++) begin
      logic [7:0]  low = 8'($urandom % 24);
      logic [1:0]  be  = 2'($urandom % 4);
      logic [15:0] d   = 16'($urandom);
      if ($urandom % 2) doWrite(low, d, be);
      else doRead(low, be);
    end
    for (int k = 0; k < 24; k++) doRead(8'(k), 2'b11);

    waitIdle();
    repeat (2) @(negedge clk);
    chk(idleViol == 0, "R1 idle pin violations", idleViol, 0);
    chk(dataViol == 0, "R4 data movement during pulse", dataViol, 0);
    chk(addrViol == 0, "R5 address movement while selected", addrViol, 0);
    chk(mapViol == 0, "R5 write address upper bits", mapViol, 0);
    chk(ovlViol == 0, "R6 enable overlap", ovlViol, 0);
    chk(turnViol == 0, "R7 bus turnaround", turnViol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule